// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Controller

The controller gathers a vector of asynchronous interrupt lines and conditions each line according to a per-source trigger code. A source can react to a rising edge, a falling edge, an active-high level or an active-low level, or it can be turned off. Edge events are caught in sticky latches, one latch for rising edges and one for falling edges, and software releases them. A level source stays pending only while its input is at the active level, so software acknowledges it by masking it.

Every pending source that is both unmasked and selected is steered to one of two processor request lines, so software can place sources in a high-priority group and a low-priority group. Two read-only status words show which sources are pending on each line. All control is written through a flat register bus. Each field has one address that sets bits and another that clears bits, so no read-modify-write is ever needed.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every field reads 0, both status words read 0, and `req0_o` and `req1_o` are low.
- R2: Field k has its SET address at 2k and its CLEAR address at 2k+1. Reading either address returns the field. The fields are k=0 cfg0, 1 cfg1, 2 cfg2, 3 mask, 4 route, 5 select, 6 rising latch, 7 falling latch. A 1 in bit n of the write data sets or clears only bit n, and 0 bits leave the field unchanged.
- R3: Trigger code {cfg2,cfg1,cfg0} = 001 captures a rising edge of input n into rising-latch bit n. The source is then pending while that latch bit is 1.
- R4: Code 010 captures a falling edge into falling-latch bit n. Both latches are sticky: a latch bit goes to 0 only when 1 is written to bit n at its CLEAR address (13 for rising, 15 for falling).
- R5: Code 101 makes a source pending while its input is high. Code 110 makes it pending while its input is low. Neither code uses a latch.
- R6: Code 000 and the codes 011, 100 and 111 never make a source pending.
- R7: A pending source with route bit 1 appears only in status word 0 (read address 16). With route bit 0 it appears only in status word 1 (read address 17). Bit n of each word corresponds to source n.
- R8: A source appears in a status word only while its mask bit and its select bit are both 1. The latches still capture edges while a source is masked.
- R9: `req0_o` and `req1_o` are registered, active-high ORs of status word 0 and status word 1, one cycle behind the word.
- R10: When a latch CLEAR write and a new captured edge hit the same bit in the same cycle, the latch bit ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Asynchronous interrupt inputs |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | N_SRC | Write data (bit mask) |
| rdata_o | output | N_SRC | Read data for `addr_i` |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |

## Verification
The bench builds the controller with its defaults, N_SRC=32 and ADDR_W=5. Full 32-bit words therefore pass over the bus, and both source 0 and source 31 are reachable. A vector table drives every valid trigger code in both input directions on sources spread across the word, and it also drives the reserved codes. Directed tests pin the edge-detect cycle, which puts a CLEAR write exactly on a fresh edge, and they cover mask and select gating and partial set/clear masks.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [2:0] {
    TRIG_OFF  = 3'b000,
    TRIG_RISE = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_HIGH = 3'b101,
    TRIG_LOW  = 3'b110
  } trig_e;

  localparam int N_FIELDS = 8;
  localparam int FLD_CFG0 = 0;
  localparam int FLD_CFG1 = 1;
  localparam int FLD_CFG2 = 2;
  localparam int FLD_MASK = 3;
  localparam int FLD_ROUTE = 4;
  localparam int FLD_SEL = 5;
  localparam int FLD_RISE = 6;
  localparam int FLD_FALL = 7;
  localparam int STAT0_ADDR = 2 * N_FIELDS;
  localparam int STAT1_ADDR = 2 * N_FIELDS + 1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [N_SRC-1:0]                 wdata_i,
  input  logic [N_SRC-1:0]                 rise_hit_i,
  input  logic [N_SRC-1:0]                 fall_hit_i,
  output logic [N_FIELDS-1:0][N_SRC-1:0]   fld_o
);
  for (genvar k = 0; k < N_FIELDS; k++) begin : g_fld
    logic [N_SRC-1:0] set_w, clr_w, hw_w, q;
    assign set_w = (we_i && addr_i == ADDR_W'(2 * k))     ? wdata_i : '0;
    assign clr_w = (we_i && addr_i == ADDR_W'(2 * k + 1)) ? wdata_i : '0;
    if (k == FLD_RISE) begin : g_rise
      assign hw_w = rise_hit_i;
    end else if (k == FLD_FALL) begin : g_fall
      assign hw_w = fall_hit_i;
    end else begin : g_plain
      assign hw_w = '0;
    end
    // captured edge overrides a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= ((q | set_w) & ~clr_w) | hw_w;
    end
    assign fld_o[k] = q;
  end
endmodule

// File: rtl/irq_cond.sv
module irq_cond
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic [N_FIELDS-1:0][N_SRC-1:0] fld_i,
  input  logic [N_SRC-1:0]               lvl_i,
  input  logic [N_SRC-1:0]               prev_i,
  output logic [N_SRC-1:0]               rise_hit_o,
  output logic [N_SRC-1:0]               fall_hit_o,
  output logic [N_SRC-1:0]               stat0_o,
  output logic [N_SRC-1:0]               stat1_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [2:0] code;
    logic       pend, gate;
    assign code = {fld_i[FLD_CFG2][i], fld_i[FLD_CFG1][i], fld_i[FLD_CFG0][i]};
    assign rise_hit_o[i] = (code == TRIG_RISE) &&  lvl_i[i] && !prev_i[i];
    assign fall_hit_o[i] = (code == TRIG_FALL) && !lvl_i[i] &&  prev_i[i];
    always_comb begin
      unique case (code)
        TRIG_RISE: pend = fld_i[FLD_RISE][i];
        TRIG_FALL: pend = fld_i[FLD_FALL][i];
        TRIG_HIGH: pend = lvl_i[i];
        TRIG_LOW:  pend = !lvl_i[i];
        default:   pend = 1'b0;
      endcase
    end
    assign gate = pend && fld_i[FLD_MASK][i] && fld_i[FLD_SEL][i];
    assign stat0_o[i] = gate &&  fld_i[FLD_ROUTE][i];
    assign stat1_o[i] = gate && !fld_i[FLD_ROUTE][i];
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              req0_o,
  output logic              req1_o
);
  localparam int FLD_AW = $clog2(N_FIELDS);

  logic [N_SRC-1:0] lvl, prev, rise_hit, fall_hit, stat0, stat1;
  logic [N_FIELDS-1:0][N_SRC-1:0] fld;
  logic req0_q, req1_q;

  irq_sync #(.W(N_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .lvl_o (lvl),
    .prev_o(prev)
  );

  irq_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rise_hit_i(rise_hit),
    .fall_hit_i(fall_hit),
    .fld_o     (fld)
  );

  irq_cond #(.N_SRC(N_SRC)) u_cond (
    .fld_i     (fld),
    .lvl_i     (lvl),
    .prev_i    (prev),
    .rise_hit_o(rise_hit),
    .fall_hit_o(fall_hit),
    .stat0_o   (stat0),
    .stat1_o   (stat1)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i < ADDR_W'(2 * N_FIELDS))  rdata_o = fld[addr_i[FLD_AW:1]];
    else if (addr_i == ADDR_W'(STAT0_ADDR)) rdata_o = stat0;
    else if (addr_i == ADDR_W'(STAT1_ADDR)) rdata_o = stat1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req0_q <= 1'b0;
      req1_q <= 1'b0;
    end else begin
      req0_q <= |stat0;
      req1_q <= |stat1;
    end
  end

  assign req0_o = req0_q;
  assign req1_o = req1_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 5
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           we_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [N_SRC-1:0]               wdata_i,
  input logic                           req0_o,
  input logic                           req1_o,
  input logic [N_FIELDS-1:0][N_SRC-1:0] fld_i,
  input logic [N_SRC-1:0]               stat0_i,
  input logic [N_SRC-1:0]               stat1_i
);
  logic started_q;
  logic [N_SRC-1:0] bad_code, clr_rise, clr_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      bad_code[i] = !({fld_i[FLD_CFG2][i], fld_i[FLD_CFG1][i], fld_i[FLD_CFG0][i]}
                      inside {3'b001, 3'b010, 3'b101, 3'b110});
    end
  end

  assign clr_rise = (we_i && addr_i == ADDR_W'(2 * FLD_RISE + 1)) ? wdata_i : '0;
  assign clr_fall = (we_i && addr_i == ADDR_W'(2 * FLD_FALL + 1)) ? wdata_i : '0;

  a_r9_req_lines: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    (req0_o == $past(stat0_i != '0)) && (req1_o == $past(stat1_i != '0)));

  a_r8_gating: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat0_i | stat1_i) & ~(fld_i[FLD_MASK] & fld_i[FLD_SEL])) == '0);

  a_r7_routing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat0_i & ~fld_i[FLD_ROUTE]) == '0) && ((stat1_i & fld_i[FLD_ROUTE]) == '0));

  a_r6_no_pend_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat0_i | stat1_i) & bad_code) == '0);

  a_r4_rise_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    ($past(fld_i[FLD_RISE]) & ~fld_i[FLD_RISE] & ~$past(clr_rise)) == '0);

  a_r4_fall_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    ($past(fld_i[FLD_FALL]) & ~fld_i[FLD_FALL] & ~$past(clr_fall)) == '0);
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .req0_o (req0_o),
  .req1_o (req1_o),
  .fld_i  (fld),
  .stat0_i(stat0),
  .stat1_i(stat1)
);

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
  localparam int N  = 32;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [N-1:0] irq = '0, wdata = '0, rdata;
  logic [AW-1:0] addr = '0;
  logic req0, req1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_ctrl #(.N_SRC(N), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .req0_o(req0), .req1_o(req1)
  );

  typedef struct packed {
    logic [2:0] code;
    logic       route;
    logic       pin_a;
    logic       pin_b;
    logic       exp;
    logic [4:0] src;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 5'd0},   // R3 rise seen
    '{3'b001, 1'b0, 1'b1, 1'b0, 1'b0, 5'd3},   // R3 fall ignored
    '{3'b010, 1'b0, 1'b1, 1'b0, 1'b1, 5'd31},  // R4 fall seen
    '{3'b010, 1'b1, 1'b0, 1'b1, 1'b0, 5'd9},   // R4 rise ignored
    '{3'b101, 1'b1, 1'b0, 1'b1, 1'b1, 5'd12},  // R5 high
    '{3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 5'd15},
    '{3'b110, 1'b0, 1'b1, 1'b0, 1'b1, 5'd18},  // R5 low
    '{3'b110, 1'b1, 1'b0, 1'b1, 1'b0, 5'd21},
    '{3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 5'd24},  // R6
    '{3'b011, 1'b1, 1'b0, 1'b1, 1'b0, 5'd27},
    '{3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 5'd30},
    '{3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 5'd1},
    '{3'b111, 1'b0, 1'b0, 1'b1, 1'b0, 5'd2},
    '{3'b101, 1'b0, 1'b0, 1'b1, 1'b1, 5'd31}   // R7 route to line 1
  };

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk); we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [N-1:0] d);
    @(negedge clk); addr = AW'(a); #1; d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    for (int k = 0; k < 8; k++) wr(2 * k + 1, '1);
  endtask

  task automatic program_src(input int s, input logic [2:0] code, input logic route);
    for (int k = 0; k < 3; k++) wr(2 * k + (code[k] ? 0 : 1), N'(1) << s);
    wr(route ? 8 : 9, N'(1) << s);
    wr(6, N'(1) << s);
    wr(10, N'(1) << s);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] bit_n;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    for (int a = 0; a < 18; a += 2) begin
      rd(a, v); chk("R1 field reset", v, '0);
    end
    rd(17, v); chk("R1 stat1 reset", v, '0);
    chk("R1 req0 reset", N'(req0), '0);
    chk("R1 req1 reset", N'(req1), '0);

    // vector table: R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      bit_n = N'(1) << VECS[i].src;
      program_src(int'(VECS[i].src), VECS[i].code, VECS[i].route);
      irq[VECS[i].src] = VECS[i].pin_a;
      cyc(8);
      wr(13, '1); wr(15, '1);
      irq[VECS[i].src] = VECS[i].pin_b;
      cyc(8);
      rd(16, v); chk($sformatf("R7 stat0 vec%0d", i), v, (VECS[i].exp && VECS[i].route) ? bit_n : '0);
      rd(17, v); chk($sformatf("R7 stat1 vec%0d", i), v, (VECS[i].exp && !VECS[i].route) ? bit_n : '0);
      chk($sformatf("R9 req0 vec%0d", i), N'(req0), N'(VECS[i].exp && VECS[i].route));
      chk($sformatf("R9 req1 vec%0d", i), N'(req1), N'(VECS[i].exp && !VECS[i].route));
      clear_all();
      irq = '0;
      cyc(8);
      wr(13, '1); wr(15, '1);
    end

    // R2 partial set/clear and zero writes
    wr(6, 32'h0000_00F0);
    wr(7, 32'h0000_0030);
    rd(6, v); chk("R2 mask set/clear", v, 32'h0000_00C0);
    wr(6, '0); wr(7, '0);
    rd(7, v); chk("R2 zero writes no effect", v, 32'h0000_00C0);
    wr(8, 32'h8000_0001);
    rd(8, v); chk("R2 route field", v, 32'h8000_0001);
    clear_all();

    // R8 masking: latch still captures, output gated
    program_src(5, 3'b001, 1'b0);
    wr(7, 32'h20);
    irq[5] = 1'b1; cyc(8);
    rd(17, v); chk("R8 masked not pending", v, '0);
    rd(12, v); chk("R8 latch captures while masked", v, 32'h20);
    chk("R8 masked req1 low", N'(req1), '0);
    wr(6, 32'h20); cyc(2);
    rd(17, v); chk("R8 unmask pending", v, 32'h20);
    chk("R9 req1 high", N'(req1), 1);
    // R4 sticky after input drops
    irq[5] = 1'b0; cyc(8);
    rd(17, v); chk("R4 rise latch sticky", v, 32'h20);
    wr(13, 32'h20); cyc(2);
    rd(17, v); chk("R4 latch cleared", v, '0);
    chk("R9 req1 drops", N'(req1), '0);
    // R8 select gate
    irq[5] = 1'b1; cyc(8);
    wr(11, 32'h20); cyc(2);
    rd(17, v); chk("R8 select off blocks", v, '0);
    clear_all(); irq = '0; cyc(8); wr(13, '1); wr(15, '1);

    // R5 level acknowledged by masking
    program_src(7, 3'b110, 1'b1);
    cyc(6);
    rd(16, v); chk("R5 low level pending", v, 32'h80);
    wr(7, 32'h80); cyc(2);
    rd(16, v); chk("R5 masked ack", v, '0);
    chk("R9 req0 after ack", N'(req0), '0);
    clear_all(); cyc(4);

    // R10 edge wins over clear, rising
    program_src(4, 3'b001, 1'b1);
    wr(12, 32'h10);
    @(negedge clk); irq[4] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = AW'(13); wdata = 32'h10;
    @(negedge clk); we = 1'b0; wdata = '0;
    rd(12, v); chk("R10 rise edge beats clear", v, 32'h10);
    wr(13, 32'h10);
    rd(12, v); chk("R10 clear without edge", v, '0);
    clear_all(); cyc(2);

    // R10 falling
    program_src(4, 3'b010, 1'b1);
    wr(14, 32'h10);
    @(negedge clk); irq[4] = 1'b0;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = AW'(15); wdata = 32'h10;
    @(negedge clk); we = 1'b0; wdata = '0;
    rd(14, v); chk("R10 fall edge beats clear", v, 32'h10);
    clear_all(); cyc(4); wr(13, '1); wr(15, '1);

    // R7 both lines at once
    program_src(0, 3'b101, 1'b1);
    program_src(31, 3'b101, 1'b0);
    irq[0] = 1'b1; irq[31] = 1'b1; cyc(6);
    rd(16, v); chk("R7 line0 word", v, 32'h0000_0001);
    rd(17, v); chk("R7 line1 word", v, 32'h8000_0000);
    chk("R9 both req", N'({req1, req0}), 3);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule